// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block runs next to a DRAM access controller and takes charge of two jobs that the controller should not have to think about: bringing the memory array out of power-up, and keeping its 2048 rows alive afterwards. Out of reset it holds every strobe inactive for the power-up pause, then runs a fixed burst of initialisation cycles on its own, each one a full refresh cycle. Only when that burst is over does it raise its ready flag. The access controller must not start a cycle of its own before then.

Once ready, an interval timer derived from the clock frequency produces one refresh obligation every 15.6 µs. Each obligation goes into a small saturating counter. While the counter is non-zero, or while a refresh cycle is running, the block asserts a request. When the controller answers with a grant, the block drives refresh cycles on all four row strobes together. It drains any backlog back to back and then releases the request.

A mode input picks the refresh style, and the block samples it at the start of each cycle. In CAS-before-RAS style the column strobes go low ahead of the row strobes. In row-address style the column strobes stay high and an internal row counter is driven on the address bus. The write enable stays high throughout.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset the row and column strobes stay high, and ready and request stay low, for at least PAUSE_US microseconds (PAUSE_US×CLK_MHZ clocks) before the first row strobe falls.
- R2: Before ready rises, exactly INIT_CYCLES (default 8) refresh cycles run without any grant. Request stays low throughout this phase, and ready rises only after the last of these cycles has finished its precharge.
- R3: The write-enable output (active low) is held high at all times.
- R4: In CAS-before-RAS mode (mode input 0), the column strobes fall at least 5 ns (2 clocks at 250 MHz) before the row strobes fall, stay low for the whole row-strobe low time, and rise together with the row strobes.
- R5: In row-address mode (mode input 1), the column strobes stay high for the whole cycle. The address output carries the row, stays stable for at least one clock before the row strobes fall, and does not change until they rise.
- R6: The row strobes stay low for at least 60 ns (15 clocks at 250 MHz) in each cycle, and stay high for at least 40 ns (10 clocks) between cycles.
- R7: The address output is an internal row counter. It starts at 0, advances by one after every refresh cycle in either mode, and goes from ROWS-1 back to 0.
- R8: After ready, one refresh obligation is added every REF_NS nanoseconds. Request is high while obligations are pending or a cycle is in progress, and no row strobe falls while grant is low.
- R9: Pending obligations saturate at PEND_MAX (default 8). Once grant is given, they run back to back with only the precharge and the column lead time (12 clocks of row strobe high at 250 MHz) between cycles. After that the request drops.
- R10: All four row strobes always carry the same value, and so do all four column strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_MHZ megahertz |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ras_only | input | 1 | 0: CAS-before-RAS refresh, 1: row-address refresh; sampled at cycle start |
| grant | input | 1 | Bus granted by the access controller |
| req | output | 1 | Refresh wants the bus |
| init_done | output | 1 | Power-up sequence complete; accesses allowed |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 4 | Column strobes, active low |
| we_n | output | 1 | Write enable, active low (always high) |
| addr | output | ROW_W | Row address for row-address refresh |

## Verification
On every clock, the bound checker enforces the strobe ordering of both refresh styles, the minimum row-strobe low and precharge times, address stability while the row strobes are low, the constant write enable, the lock-step strobe groups, and the rule that no strobe falls without a grant once ready. It also enforces the pause before the first cycle and the exact count of initialisation cycles at the moment ready rises. Only the bench scenarios can show the interval between obligations, saturation of the backlog and its back-to-back drain, the order of row addresses across the wrap, and the mode being taken from the input at each cycle start.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_MHZ     = 250,
  parameter int PAUSE_US    = 200,
  parameter int INIT_CYCLES = 8,
  parameter int ROWS        = 2048,
  parameter int REF_NS      = 15600,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_CSR_NS    = 5,
  parameter int T_CHR_NS    = 10,
  parameter int PEND_MAX    = 8,
  parameter int STROBES     = 4,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ras_only,
  input  logic               grant,
  output logic               req,
  output logic               init_done,
  output logic [STROBES-1:0] ras_n,
  output logic [STROBES-1:0] cas_n,
  output logic               we_n,
  output logic [ROW_W-1:0]   addr
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int CSR_CYC   = (T_CSR_NS * CLK_MHZ + 999) / 1000;
  localparam int SETUP_CYC = (CSR_CYC < 1) ? 1 : CSR_CYC;
  localparam int RASL_CYC  = (T_RAS_NS * CLK_MHZ + 999) / 1000;
  localparam int CHR_CYC   = (T_CHR_NS * CLK_MHZ + 999) / 1000;
  localparam int RAS_CYC   = (RASL_CYC > CHR_CYC) ? RASL_CYC : CHR_CYC;
  localparam int RP_CYC    = (T_RP_NS * CLK_MHZ + 999) / 1000;
  localparam int REF_CYC   = REF_NS * CLK_MHZ / 1000;
  localparam int TMR_W     = $clog2(PAUSE_CYC + RAS_CYC + RP_CYC + 2);
  localparam int IVL_W     = $clog2(REF_CYC + 1);
  localparam int PEND_W    = $clog2(PEND_MAX + 1);
  localparam int INIT_W    = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_SETUP, ST_ACTIVE, ST_PRE} state_t;

  state_t            st;
  logic [TMR_W-1:0]  tmr;
  logic [IVL_W-1:0]  ivl;
  logic [PEND_W-1:0] pend;
  logic [INIT_W-1:0] init_cnt;
  logic [ROW_W-1:0]  row;
  logic              cbr;

  wire tmr_zero = (tmr == '0);
  wire cyc_end  = (st == ST_PRE) && tmr_zero;
  wire ivl_tick = init_done && (ivl == IVL_W'(REF_CYC - 1));
  wire want     = init_done ? ((pend != '0) && grant)
                            : (init_cnt != INIT_W'(INIT_CYCLES - 1));
  wire go       = ((st == ST_PAUSE) && tmr_zero) ||
                  (((st == ST_IDLE) || cyc_end) && want);
  wire take     = go && init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      tmr       <= TMR_W'(PAUSE_CYC - 1);
      ivl       <= '0;
      pend      <= '0;
      init_cnt  <= '0;
      init_done <= 1'b0;
      row       <= '0;
      cbr       <= 1'b1;
    end else begin
      if (go) begin
        st  <= ST_SETUP;
        tmr <= TMR_W'(SETUP_CYC - 1);
        cbr <= ~mode_ras_only;
      end else begin
        case (st)
          ST_PAUSE: tmr <= tmr - TMR_W'(1);
          ST_SETUP:
            if (tmr_zero) begin
              st  <= ST_ACTIVE;
              tmr <= TMR_W'(RAS_CYC - 1);
            end else tmr <= tmr - TMR_W'(1);
          ST_ACTIVE:
            if (tmr_zero) begin
              st  <= ST_PRE;
              tmr <= TMR_W'(RP_CYC - 1);
            end else tmr <= tmr - TMR_W'(1);
          ST_PRE:
            if (tmr_zero) st <= ST_IDLE;
            else tmr <= tmr - TMR_W'(1);
          default: ;
        endcase
      end

      if (cyc_end) begin
        row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + ROW_W'(1);
        if (!init_done) begin
          init_cnt <= init_cnt + INIT_W'(1);
          if (init_cnt == INIT_W'(INIT_CYCLES - 1)) init_done <= 1'b1;
        end
      end

      if (!init_done || ivl_tick) ivl <= '0;
      else                        ivl <= ivl + IVL_W'(1);

      case ({ivl_tick, take})
        2'b10: if (pend != PEND_W'(PEND_MAX)) pend <= pend + PEND_W'(1);
        2'b01: pend <= pend - PEND_W'(1);
        default: ;
      endcase
    end
  end

  assign ras_n = {STROBES{st != ST_ACTIVE}};
  assign cas_n = {STROBES{~(cbr && ((st == ST_SETUP) || (st == ST_ACTIVE)))}};
  assign we_n  = 1'b1;
  assign addr  = row;
  assign req   = init_done && ((pend != '0) || (st != ST_IDLE));
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int CLK_MHZ     = 250,
  parameter int PAUSE_US    = 200,
  parameter int INIT_CYCLES = 8,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_CSR_NS    = 5,
  parameter int STROBES     = 4,
  parameter int ROW_W       = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               grant,
  input logic               req,
  input logic               init_done,
  input logic [STROBES-1:0] ras_n,
  input logic [STROBES-1:0] cas_n,
  input logic               we_n,
  input logic [ROW_W-1:0]   addr
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int LEAD_CYC  = (T_CSR_NS * CLK_MHZ + 999) / 1000;
  localparam int RAS_CYC   = (T_RAS_NS * CLK_MHZ + 999) / 1000;
  localparam int RP_CYC    = (T_RP_NS * CLK_MHZ + 999) / 1000;

  int   since, lowcnt, highcnt, lead, nfall;
  logic ras_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0; lowcnt <= 0; highcnt <= 0; lead <= 0; nfall <= 0; ras_q <= 1'b1;
    end else begin
      ras_q <= ras_n[0];
      if (since < PAUSE_CYC) since <= since + 1;
      if (ras_n[0]) lowcnt <= 0;
      else if (lowcnt < RAS_CYC) lowcnt <= lowcnt + 1;
      if (!ras_n[0]) highcnt <= 0;
      else if (highcnt < RP_CYC) highcnt <= highcnt + 1;
      if (!cas_n[0] && ras_n[0]) begin
        if (lead < LEAD_CYC) lead <= lead + 1;
      end else lead <= 0;
      if (ras_q && !ras_n[0] && !init_done && nfall < 255) nfall <= nfall + 1;
    end
  end

  assert_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> since >= PAUSE_CYC);
  assert_init_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> nfall == INIT_CYCLES);
  assert_no_req_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req);
  assert_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n) we_n);
  assert_cbr_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n[0]) && !cas_n[0]) |-> lead >= LEAD_CYC);
  assert_cas_rise_with_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n[0]) |-> $rose(ras_n[0]));
  assert_cas_no_fall_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n[0] && $past(!ras_n[0])) |-> $stable(cas_n[0]));
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> $stable(addr));
  assert_ras_low_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> lowcnt >= RAS_CYC);
  assert_ras_pre_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> highcnt >= RP_CYC);
  assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !ras_n[0]) |-> grant);
  assert_groups_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .INIT_CYCLES(INIT_CYCLES),
  .T_RAS_NS(T_RAS_NS), .T_RP_NS(T_RP_NS), .T_CSR_NS(T_CSR_NS),
  .STROBES(STROBES), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .init_done(init_done),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  localparam int ROWS   = 16;
  localparam int ROW_W  = 4;
  localparam int PAUSE  = 500;
  localparam int REF    = 500;
  localparam int LEAD   = 2;
  localparam int RASC   = 15;
  localparam int RPC    = 10;
  localparam int NINIT  = 8;
  localparam int NVEC   = 6;
  localparam logic [8:0] VECS [0:NVEC-1] = '{
    {1'b0, 8'd0}, {1'b1, 8'd0}, {1'b0, 8'd7},
    {1'b1, 8'd3}, {1'b1, 8'd20}, {1'b0, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, grant = 1'b0;
  logic req, init_done, we_n;
  logic [3:0] ras_n, cas_n;
  logic [ROW_W-1:0] addr;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(.CLK_MHZ(250), .PAUSE_US(2), .INIT_CYCLES(NINIT), .ROWS(ROWS),
                     .REF_NS(2000)) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode), .grant(grant), .req(req),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr));

  // monitor
  int edges = 0, nfall = 0, first_fall = -1, pre_falls = 0, req_early = 0;
  int cas_run = 0, lead_last = 0, cur_low = 0, low_last = 0, high_run = 1000;
  int min_low = 1000, min_gap = 1000, we_bad = 0, split_bad = 0, wrap_seen = 0;
  int addr_fall = 0, prev_addr_fall = -1, addr_ok = 1;
  logic cas_at_fall = 1'b1, cas_moved = 1'b0, addr_moved = 1'b0, prev_low = 1'b0;

  always @(negedge clk) if (rst_n) begin
    logic low;
    edges++;
    low = (ras_n == 4'h0);
    if (!we_n) we_bad++;
    if (!(ras_n == 4'h0 || ras_n == 4'hF) || !(cas_n == 4'h0 || cas_n == 4'hF)) split_bad++;
    if (!init_done && req) req_early++;
    if (low && !prev_low) begin
      nfall++;
      if (first_fall < 0) first_fall = edges;
      if (!init_done) pre_falls++;
      if (nfall > 1 && high_run < min_gap) min_gap = high_run;
      lead_last = cas_run; cas_at_fall = cas_n[0]; cas_moved = 1'b0; addr_moved = 1'b0;
      prev_addr_fall = addr_fall; addr_fall = int'(addr); cur_low = 1;
      if (addr_fall != (nfall - 1) % ROWS) addr_ok = 0;
      if (nfall > 1 && prev_addr_fall == ROWS - 1 && addr_fall == 0) wrap_seen = 1;
    end else if (low) begin
      cur_low++;
      if (cas_n[0] != cas_at_fall) cas_moved = 1'b1;
      if (int'(addr) != addr_fall) addr_moved = 1'b1;
    end
    if (!low && prev_low) begin
      low_last = cur_low; high_run = 1;
      if (cur_low < min_low) min_low = cur_low;
    end else if (!low) high_run++;
    if (!low) cas_run = (cas_n[0] == 1'b0) ? cas_run + 1 : 0;
    prev_low = low;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, cnt, gaps_bad, hr, waited;
    logic pl;
    repeat (3) tick();
    // reset state (R1, R3)
    check(ras_n == 4'hF, "R1 ras idle in reset", ras_n, 15);
    check(cas_n == 4'hF, "R1 cas idle in reset", cas_n, 15);
    check(req == 1'b0, "R1 req low in reset", req, 0);
    check(init_done == 1'b0, "R1 not ready in reset", init_done, 0);
    check(we_n == 1'b1, "R3 we high in reset", we_n, 1);
    rst_n = 1'b1;

    waited = 0;
    while (!init_done && waited < 3000) begin tick(); waited++; end
    check(first_fall >= PAUSE, "R1 pause before first cycle", first_fall, PAUSE);
    check(init_done == 1'b1, "R2 ready reached", init_done, 1);
    check(pre_falls == NINIT, "R2 init cycle count", pre_falls, NINIT);
    check(req_early == 0, "R2 no request during init", req_early, 0);
    check(ras_n == 4'hF, "R2 ready after last precharge", ras_n, 15);

    // table of single refresh cycles (R4 R5 R6 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      waited = 0;
      while (!req && waited < 2 * REF) begin tick(); waited++; end
      check(req == 1'b1, "R8 request raised per interval", req, 1);
      mode = VECS[i][8];
      n0 = nfall;
      repeat (int'(VECS[i][7:0])) tick();
      check(nfall == n0, "R8 no cycle before grant", nfall - n0, 0);
      grant = 1'b1;
      waited = 0;
      while (req && waited < 200) begin tick(); waited++; end
      grant = 1'b0;
      check(nfall == n0 + 1, "R8 one cycle per obligation", nfall - n0, 1);
      if (VECS[i][8]) begin
        check(lead_last == 0 && cas_at_fall == 1'b1, "R5 cas high in row-address mode",
              lead_last, 0);
        check(!addr_moved, "R5 address stable while ras low", addr_moved, 0);
      end else begin
        check(lead_last >= LEAD && cas_at_fall == 1'b0, "R4 cas leads ras", lead_last, LEAD);
        check(!cas_moved, "R4 cas held low with ras", cas_moved, 0);
      end
      check(low_last == RASC, "R6 ras low length", low_last, RASC);
      check(addr_fall == (nfall - 1) % ROWS, "R7 row address order", addr_fall,
            (nfall - 1) % ROWS);
    end

    // saturation and back-to-back drain (R8 R9)
    waited = 0;
    while (!req && waited < 2 * REF) begin tick(); waited++; end
    n0 = nfall;
    repeat (9 * REF + 100) tick();
    check(nfall == n0, "R8 no cycle while grant low", nfall - n0, 0);
    check(req == 1'b1, "R8 request held while pending", req, 1);
    mode = 1'b0;
    grant = 1'b1;
    cnt = 0; gaps_bad = 0; hr = 0; pl = 1'b0; waited = 0;
    while (waited < 400) begin
      tick(); waited++;
      if (ras_n == 4'h0 && !pl) begin
        cnt++;
        if (cnt > 1 && hr != RPC + LEAD) gaps_bad++;
      end
      hr = (ras_n == 4'h0) ? 0 : hr + 1;
      pl = (ras_n == 4'h0);
      if (!req) break;
    end
    grant = 1'b0;
    check(cnt == 8, "R9 backlog saturates at eight", cnt, 8);
    check(gaps_bad == 0, "R9 back-to-back drain", gaps_bad, 0);
    check(req == 1'b0, "R9 request drops after drain", req, 0);

    check(addr_ok == 1, "R7 addresses in sequence", addr_ok, 1);
    check(wrap_seen == 1, "R7 row counter wraps", wrap_seen, 1);
    check(min_low >= RASC, "R6 minimum ras low", min_low, RASC);
    check(min_gap >= RPC, "R6 minimum precharge", min_gap, RPC);
    check(we_bad == 0, "R3 write enable never low", we_bad, 0);
    check(split_bad == 0, "R10 strobe groups in lock-step", split_bad, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule